// File: doc/BRIEF.md
# Mailbox Read Coherency Lock

This block sits between the processor's register read port and a set of receive mailboxes. It makes sure that software always sees a consistent copy of a received frame. Each mailbox holds a status code and a payload word. Received frames reach the block with the index of the mailbox they matched. A frame is normally moved into its mailbox over a fixed number of cycles. During those cycles the mailbox's status word shows a busy bit.

The lock is never set through a register. It is a side effect of ordinary reads. Reading a mailbox's status word locks that mailbox. Reading the free-running timer releases the lock. Reading the status word of a different mailbox moves the lock to that mailbox, so at most one mailbox is locked at any time. A frame that matches the locked mailbox is parked in a single holding buffer. Its move-in starts on the clock edge at which the lock is released. If a newer frame for the same mailbox arrives while one is still parked, the newer frame replaces it, and the mailbox ends up marked as overrun.

Top module: `mbx_read_lock`

## Requirements
- R1: A status-word read (`cpu_rd_en`=1, `cpu_rd_sel`=0) of mailbox m sets `lock_valid`=1 and `lock_mb`=m from the next cycle on.
- R2: A timer read (`cpu_rd_sel`=2) returns the timer value and clears `lock_valid` from the next cycle on. The timer counts clock cycles since reset, so two timer reads in consecutive cycles differ by exactly 1.
- R3: A status-word read of a different mailbox moves the lock to that mailbox, so that only one mailbox is ever locked.
- R4: Payload reads (`cpu_rd_sel`=1), reads with `cpu_rd_sel`=3 and cycles without a read leave `lock_valid` and `lock_mb` unchanged.
- R5: A frame for an unlocked, active mailbox shows the busy bit (bit 0 of the status word) for MOVE_CYC cycles, starting in the cycle after `rx_valid`. After that the payload is stored, and the code goes from EMPTY (4'b0100) to FULL (4'b0010).
- R6: A frame for the locked mailbox leaves that mailbox's payload and code unchanged and not busy while the lock holds. Its move-in starts on the edge at which the lock is released, so busy is visible in the next cycle.
- R7: A second frame for a mailbox whose earlier frame is still held replaces it. After the move-in, the mailbox holds the newer payload with code OVERRUN (4'b0110).
- R8: A frame moved into a mailbox whose code is FULL or OVERRUN leaves the code OVERRUN.
- R9: Releasing the lock leaves a FULL mailbox's code FULL; it does not return to EMPTY.
- R10: Frames for an INACTIVE (4'b0000) mailbox are dropped. A held frame whose mailbox is made INACTIVE before the release is also dropped.
- R11: Reset clears the lock, the holding buffer and the timer, and sets every mailbox to INACTIVE with a zero payload.
- R12: A code write stores `cpu_wr_code` with bit 0 forced to zero, and the status word reads back that code. `cpu_rd_data` is zero when `cpu_rd_en`=0, and the status word is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd_en | input | 1 | Read strobe |
| cpu_rd_sel | input | 2 | 0 status word, 1 payload, 2 timer, 3 none |
| cpu_rd_mb | input | MB_W | Mailbox index of the read |
| cpu_rd_data | output | PAY_W | Read data, combinational |
| cpu_wr_en | input | 1 | Code write strobe |
| cpu_wr_mb | input | MB_W | Mailbox index of the code write |
| cpu_wr_code | input | 4 | Code to write |
| rx_valid | input | 1 | Matched frame present |
| rx_mb | input | MB_W | Mailbox the frame matched |
| rx_payload | input | PAY_W | Frame payload |
| lock_valid | output | 1 | A mailbox is locked |
| lock_mb | output | MB_W | Index of the locked mailbox |

## Verification
The assertions rely on three assumptions about the inputs. Frames for a given mailbox arrive at least MOVE_CYC+2 cycles apart. No frame targets a mailbox whose move-in is running. Software never writes a code to a mailbox while it is busy. The stimulus respects all three by inserting idle cycles after every frame and by issuing code writes only to idle mailboxes. Under these assumptions, the properties check three things: a move-in never starts into the locked mailbox, a replaced held frame always carries the overrun mark, and a frame for an inactive mailbox changes nothing.

// File: rtl/mlk_pkg.sv
package mlk_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;

  typedef enum logic [1:0] {
    RD_CSW  = 2'd0,
    RD_PAY  = 2'd1,
    RD_TMR  = 2'd2,
    RD_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/mlk_timer.sv
module mlk_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TMR_W-1:0] count
);
  logic [TMR_W-1:0] count_q, count_n;

  always_comb begin
    count_n = count_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_n;
  end

  assign count = count_q;
endmodule

// File: rtl/mlk_lock_track.sv
module mlk_lock_track
  import mlk_pkg::*;
#(
  parameter int MB_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [1:0]      rd_sel,
  input  logic [MB_W-1:0] rd_mb,
  output logic            lock_valid,
  output logic [MB_W-1:0] lock_mb,
  output logic            lock_valid_nxt,
  output logic [MB_W-1:0] lock_mb_nxt
);
  logic            valid_q;
  logic [MB_W-1:0] mb_q;
  logic            take, drop, lock_en;

  always_comb begin
    take           = rd_en && (rd_sel == RD_CSW);
    drop           = rd_en && (rd_sel == RD_TMR);
    lock_en        = take || drop;
    lock_valid_nxt = valid_q;
    lock_mb_nxt    = mb_q;
    if (take) begin
      lock_valid_nxt = 1'b1;
      lock_mb_nxt    = rd_mb;
    end else if (drop) begin
      lock_valid_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mb_q    <= '0;
    end else if (lock_en) begin
      valid_q <= lock_valid_nxt;
      mb_q    <= lock_mb_nxt;
    end
  end

  assign lock_valid = valid_q;
  assign lock_mb    = mb_q;

  assert_csw_read_locks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_sel == RD_CSW |=> lock_valid && lock_mb == $past(rd_mb));

  assert_timer_read_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_sel == RD_TMR |=> !lock_valid);

  assert_single_lock_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_valid && rd_en && rd_sel == RD_CSW && rd_mb != lock_mb |=> lock_mb != $past(lock_mb));

  assert_other_reads_keep_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (rd_sel == RD_CSW || rd_sel == RD_TMR)) |=> $stable(lock_valid) && $stable(lock_mb));
endmodule

// File: rtl/mlk_hold_buf.sv
module mlk_hold_buf #(
  parameter int MB_W  = 3,
  parameter int PAY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [MB_W-1:0]  cap_mb,
  input  logic [PAY_W-1:0] cap_pay,
  input  logic             cap_ovr,
  input  logic             drain,
  output logic             hold_valid,
  output logic [MB_W-1:0]  hold_mb,
  output logic [PAY_W-1:0] hold_pay,
  output logic             hold_ovr
);
  logic             valid_q, valid_n;
  logic [MB_W-1:0]  mb_q;
  logic [PAY_W-1:0] pay_q;
  logic             ovr_q;

  always_comb begin
    valid_n = valid_q;
    if (capture)    valid_n = 1'b1;
    else if (drain) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q  <= '0;
      pay_q <= '0;
      ovr_q <= 1'b0;
    end else if (capture) begin
      mb_q  <= cap_mb;
      pay_q <= cap_pay;
      ovr_q <= cap_ovr;
    end
  end

  assign hold_valid = valid_q;
  assign hold_mb    = mb_q;
  assign hold_pay   = pay_q;
  assign hold_ovr   = ovr_q;

  assert_drain_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !capture |=> !hold_valid);
endmodule

// File: rtl/mlk_slot.sv
module mlk_slot
  import mlk_pkg::*;
#(
  parameter int PAY_W    = 32,
  parameter int MOVE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PAY_W-1:0] start_pay,
  input  logic             start_ovr,
  input  logic             wr_en,
  input  logic [3:0]       wr_code,
  output logic [3:0]       code,
  output logic             busy,
  output logic [PAY_W-1:0] payload
);
  localparam int CNT_W = (MOVE_CYC > 1) ? $clog2(MOVE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MOVE_CYC - 1);

  logic [3:0]       code_q, code_n;
  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [PAY_W-1:0] pay_q, pay_n;
  logic [PAY_W-1:0] stg_q;
  logic             ovr_q;
  logic             commit;

  always_comb begin
    code_n = code_q;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    pay_n  = pay_q;
    commit = busy_q && (cnt_q == '0);
    if (wr_en) code_n = {wr_code[3:1], 1'b0};
    if (busy_q) begin
      if (commit) begin
        busy_n = 1'b0;
        pay_n  = stg_q;
        code_n = (ovr_q || code_q == CODE_FULL || code_q == CODE_OVERRUN)
                 ? CODE_OVERRUN : CODE_FULL;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_INACTIVE;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pay_q  <= '0;
    end else begin
      code_q <= code_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      pay_q  <= pay_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      ovr_q <= 1'b0;
    end else if (start) begin
      stg_q <= start_pay;
      ovr_q <= start_ovr;
    end
  end

  assign code    = code_q;
  assign busy    = busy_q;
  assign payload = pay_q;

  assert_start_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  assert_commit_marks_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (code_q == CODE_FULL || code_q == CODE_OVERRUN));

  assert_busy_then_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
endmodule

// File: rtl/mbx_read_lock.sv
module mbx_read_lock
  import mlk_pkg::*;
#(
  parameter int NUM_MB   = 8,
  parameter int PAY_W    = 32,
  parameter int TMR_W    = 16,
  parameter int MOVE_CYC = 2,
  localparam int MB_W    = $clog2(NUM_MB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_rd_en,
  input  logic [1:0]       cpu_rd_sel,
  input  logic [MB_W-1:0]  cpu_rd_mb,
  output logic [PAY_W-1:0] cpu_rd_data,
  input  logic             cpu_wr_en,
  input  logic [MB_W-1:0]  cpu_wr_mb,
  input  logic [3:0]       cpu_wr_code,
  input  logic             rx_valid,
  input  logic [MB_W-1:0]  rx_mb,
  input  logic [PAY_W-1:0] rx_payload,
  output logic             lock_valid,
  output logic [MB_W-1:0]  lock_mb
);
  logic [3:0]       slot_code [NUM_MB];
  logic [PAY_W-1:0] slot_pay  [NUM_MB];
  logic [NUM_MB-1:0] slot_busy;

  logic             lock_v_nxt;
  logic [MB_W-1:0]  lock_m_nxt;
  logic             hold_valid, hold_ovr;
  logic [MB_W-1:0]  hold_mb;
  logic [PAY_W-1:0] hold_pay;
  logic [TMR_W-1:0] tmr_val;

  logic rx_act, rx_locked, replace, rx_hold, rx_direct;
  logic hold_locked, launch, launch_go;

  mlk_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .count(tmr_val)
  );

  mlk_lock_track #(.MB_W(MB_W)) u_lock (
    .clk(clk), .rst_n(rst_n),
    .rd_en(cpu_rd_en), .rd_sel(cpu_rd_sel), .rd_mb(cpu_rd_mb),
    .lock_valid(lock_valid), .lock_mb(lock_mb),
    .lock_valid_nxt(lock_v_nxt), .lock_mb_nxt(lock_m_nxt)
  );

  always_comb begin
    rx_act      = rx_valid && (slot_code[rx_mb] != CODE_INACTIVE);
    rx_locked   = lock_v_nxt && (lock_m_nxt == rx_mb);
    replace     = rx_act && hold_valid && (hold_mb == rx_mb);
    rx_hold     = rx_act && (rx_locked || replace);
    rx_direct   = rx_act && !rx_hold;
    hold_locked = lock_v_nxt && (lock_m_nxt == hold_mb);
    launch      = hold_valid && !replace && !hold_locked && !slot_busy[hold_mb];
    launch_go   = launch && (slot_code[hold_mb] != CODE_INACTIVE);
  end

  mlk_hold_buf #(.MB_W(MB_W), .PAY_W(PAY_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .capture(rx_hold), .cap_mb(rx_mb), .cap_pay(rx_payload), .cap_ovr(replace),
    .drain(launch),
    .hold_valid(hold_valid), .hold_mb(hold_mb), .hold_pay(hold_pay), .hold_ovr(hold_ovr)
  );

  for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
    logic hit_rx, hit_hold, hit_wr;
    assign hit_rx   = rx_direct && (rx_mb == MB_W'(i));
    assign hit_hold = launch_go && (hold_mb == MB_W'(i));
    assign hit_wr   = cpu_wr_en && (cpu_wr_mb == MB_W'(i));

    mlk_slot #(.PAY_W(PAY_W), .MOVE_CYC(MOVE_CYC)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .start(hit_rx || hit_hold),
      .start_pay(hit_hold ? hold_pay : rx_payload),
      .start_ovr(hit_hold && hold_ovr),
      .wr_en(hit_wr), .wr_code(cpu_wr_code),
      .code(slot_code[i]), .busy(slot_busy[i]), .payload(slot_pay[i])
    );

    assert_no_movein_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_busy[i]) |-> !(lock_valid && lock_mb == MB_W'(i)));
  end

  always_comb begin
    cpu_rd_data = '0;
    if (cpu_rd_en) begin
      case (cpu_rd_sel)
        RD_CSW:  cpu_rd_data = PAY_W'({slot_code[cpu_rd_mb][3:1], slot_busy[cpu_rd_mb]});
        RD_PAY:  cpu_rd_data = slot_pay[cpu_rd_mb];
        RD_TMR:  cpu_rd_data = PAY_W'(tmr_val);
        default: cpu_rd_data = '0;
      endcase
    end
  end

  assert_replace_marks_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    replace |=> hold_valid && hold_ovr);

  assert_inactive_drops_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && slot_code[rx_mb] == CODE_INACTIVE && !slot_busy[rx_mb] && !cpu_wr_en
    |=> slot_code[$past(rx_mb)] == CODE_INACTIVE && !slot_busy[$past(rx_mb)]);
endmodule

// File: tb/sim_mbx_read_lock.sv
module sim_mbx_read_lock;
  localparam int NMB = 8;
  localparam int MBW = 3;
  localparam int PW  = 32;
  localparam int TW  = 16;
  localparam int MC  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_rd_en = 1'b0;
  logic [1:0]    cpu_rd_sel = 2'd0;
  logic [MBW-1:0] cpu_rd_mb = '0;
  logic [PW-1:0] cpu_rd_data;
  logic          cpu_wr_en = 1'b0;
  logic [MBW-1:0] cpu_wr_mb = '0;
  logic [3:0]    cpu_wr_code = '0;
  logic          rx_valid = 1'b0;
  logic [MBW-1:0] rx_mb = '0;
  logic [PW-1:0] rx_payload = '0;
  logic          lock_valid;
  logic [MBW-1:0] lock_mb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbx_read_lock #(.NUM_MB(NMB), .PAY_W(PW), .TMR_W(TW), .MOVE_CYC(MC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_sel(cpu_rd_sel), .cpu_rd_mb(cpu_rd_mb),
    .cpu_rd_data(cpu_rd_data),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_mb(cpu_wr_mb), .cpu_wr_code(cpu_wr_code),
    .rx_valid(rx_valid), .rx_mb(rx_mb), .rx_payload(rx_payload),
    .lock_valid(lock_valid), .lock_mb(lock_mb)
  );

  // behavioural reference model
  logic [3:0]  m_code [NMB];
  logic [PW-1:0] m_pay [NMB];
  logic [PW-1:0] m_stg [NMB];
  bit          m_sovr [NMB];
  bit          m_busy [NMB];
  int          m_cnt  [NMB];
  bit          m_lv;
  int          m_lm;
  bit          m_hv;
  int          m_hm;
  logic [PW-1:0] m_hp;
  bit          m_hovr;
  int          m_tmr;

  task automatic model_reset();
    for (int i = 0; i < NMB; i++) begin
      m_code[i] = 4'b0000; m_pay[i] = '0; m_stg[i] = '0;
      m_sovr[i] = 0; m_busy[i] = 0; m_cnt[i] = 0;
    end
    m_lv = 0; m_lm = 0; m_hv = 0; m_hm = 0; m_hp = '0; m_hovr = 0; m_tmr = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit nlv; int nlm; bit act, rlock, repl, rhold, rdir, hlock, lnch, lgo;
      bit commit [NMB];
      int r;
      nlv = m_lv; nlm = m_lm;
      if (cpu_rd_en && cpu_rd_sel == 2'd0) begin nlv = 1; nlm = int'(cpu_rd_mb); end
      else if (cpu_rd_en && cpu_rd_sel == 2'd2) nlv = 0;
      r     = int'(rx_mb);
      act   = rx_valid && m_code[r] != 4'b0000;
      rlock = nlv && nlm == r;
      repl  = act && m_hv && m_hm == r;
      rhold = act && (rlock || repl);
      rdir  = act && !rhold;
      hlock = nlv && nlm == m_hm;
      lnch  = m_hv && !repl && !hlock && !m_busy[m_hm];
      lgo   = lnch && m_code[m_hm] != 4'b0000;
      for (int i = 0; i < NMB; i++) begin
        commit[i] = m_busy[i] && m_cnt[i] == 0;
        if (cpu_wr_en && int'(cpu_wr_mb) == i) m_code[i] = {cpu_wr_code[3:1], 1'b0};
      end
      for (int i = 0; i < NMB; i++) begin
        if (commit[i]) begin
          m_busy[i] = 0;
          m_pay[i]  = m_stg[i];
          if (m_sovr[i] || m_code[i] == 4'b0010 || m_code[i] == 4'b0110) m_code[i] = 4'b0110;
          else m_code[i] = 4'b0010;
        end else if (m_busy[i]) m_cnt[i]--;
      end
      if (rdir) begin
        m_busy[r] = 1; m_cnt[r] = MC - 1; m_stg[r] = rx_payload; m_sovr[r] = 0;
      end
      if (lgo) begin
        m_busy[m_hm] = 1; m_cnt[m_hm] = MC - 1; m_stg[m_hm] = m_hp; m_sovr[m_hm] = m_hovr;
      end
      if (rhold) begin
        m_hv = 1; m_hm = r; m_hp = rx_payload; m_hovr = repl;
      end else if (lnch) m_hv = 0;
      m_lv = nlv; m_lm = nlm;
      m_tmr = (m_tmr + 1) % (1 << TW);
    end
  end

  function automatic logic [PW-1:0] model_rd();
    int b;
    b = int'(cpu_rd_mb);
    if (!cpu_rd_en) return '0;
    case (cpu_rd_sel)
      2'd0: return PW'({m_code[b][3:1], m_busy[b]});
      2'd1: return m_pay[b];
      2'd2: return PW'(m_tmr);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    #3;
    if (!done) begin
      chk("model lock R1/R3/R4", {lock_valid, PW'(lock_mb)}, {m_lv, PW'(m_lm)});
      chk("model read data R5/R12", cpu_rd_data, model_rd());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sel, input int mb, output logic [PW-1:0] d);
    cpu_rd_en = 1; cpu_rd_sel = sel; cpu_rd_mb = MBW'(mb);
    #1 d = cpu_rd_data;
    @(negedge clk);
    cpu_rd_en = 0; cpu_rd_sel = 2'd0;
  endtask

  task automatic wrc(input int mb, input logic [3:0] c);
    cpu_wr_en = 1; cpu_wr_mb = MBW'(mb); cpu_wr_code = c;
    @(negedge clk);
    cpu_wr_en = 0;
  endtask

  task automatic rx(input int mb, input logic [PW-1:0] p);
    rx_valid = 1; rx_mb = MBW'(mb); rx_payload = p;
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] d, t1;
    idle(2);
    rst_n = 1;
    idle(1);
    // R11 reset state
    chk("R11 lock after reset", PW'(lock_valid), 0);
    rd(2'd0, 0, d); chk("R11 code after reset", d, 0);
    rd(2'd1, 4, d); chk("R11 payload after reset", d, 0);
    // R2 timer counts and releases
    rd(2'd2, 0, t1); rd(2'd2, 0, d);
    chk("R2 timer step", d, t1 + 1);
    chk("R2 unlocked", PW'(lock_valid), 0);
    // R12 code writes
    for (int i = 0; i < 4; i++) wrc(i, 4'b0101);
    wrc(6, 4'b0011);
    rd(2'd0, 0, d); chk("R12 empty written", d, 32'h4);
    rd(2'd0, 6, d); chk("R12 bit0 dropped", d, 32'h2);
    rd(2'd3, 6, d); chk("R12 sel3 reads zero", d, 0);
    // R5 direct move-in into mb1
    rd(2'd2, 0, d);
    rx(1, 32'hA1A1_0001);
    rd(2'd0, 1, d); chk("R5 busy bit", d, 32'h5);
    idle(MC - 1);
    rd(2'd0, 1, d); chk("R5 full after move-in", d, 32'h2);
    rd(2'd1, 1, d); chk("R5 payload stored", d, 32'hA1A1_0001);
    // R9 unlock keeps FULL
    rd(2'd2, 0, d);
    rd(2'd0, 1, d); chk("R9 stays full", d, 32'h2);
    // R1/R6 locked mailbox defers move-in
    rd(2'd0, 2, d);
    chk("R1 lock valid", PW'(lock_valid), 1);
    chk("R1 lock index", PW'(lock_mb), 2);
    rx(2, 32'hB2B2_0002);
    idle(4);
    rd(2'd1, 2, d); chk("R6 payload untouched", d, 0);
    chk("R4 payload read keeps lock", PW'(lock_mb), 2);
    rd(2'd0, 2, d); chk("R6 not busy while locked", d, 32'h4);
    rd(2'd2, 0, d);
    rd(2'd0, 2, d); chk("R6 busy after release", d, 32'h5);
    idle(MC - 1);
    rd(2'd1, 2, d); chk("R6 payload moved in", d, 32'hB2B2_0002);
    rd(2'd0, 2, d); chk("R6 code full", d, 32'h2);
    // R3/R7 replace while held
    rd(2'd0, 3, d);
    rx(3, 32'hC3C3_0001);
    idle(4);
    rx(3, 32'hC3C3_0002);
    idle(2);
    rd(2'd0, 0, d);
    chk("R3 lock moved", PW'(lock_mb), 0);
    idle(MC);
    rd(2'd1, 3, d); chk("R7 newer payload", d, 32'hC3C3_0002);
    rd(2'd0, 3, d); chk("R7 overrun code", d, 32'h6);
    // R8 frame into FULL mailbox
    rx(1, 32'hD1D1_0003);
    idle(MC);
    rd(2'd0, 1, d); chk("R8 overrun code", d, 32'h6);
    rd(2'd1, 1, d); chk("R8 payload", d, 32'hD1D1_0003);
    // R10 inactive mailbox and held-then-deactivated
    rx(5, 32'hE5E5_0005);
    idle(MC + 1);
    rd(2'd0, 5, d); chk("R10 inactive code", d, 0);
    rd(2'd1, 5, d); chk("R10 inactive payload", d, 0);
    rd(2'd0, 0, d);
    rx(0, 32'hF0F0_0000);
    idle(2);
    wrc(0, 4'b0000);
    rd(2'd2, 0, d);
    idle(MC + 1);
    rd(2'd1, 0, d); chk("R10 held frame dropped", d, 0);
    rd(2'd0, 0, d); chk("R10 code stays inactive", d, 0);
    // R11 reset drops lock and held frame
    rd(2'd0, 2, d);
    rx(2, 32'h1234_5678);
    idle(1);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
    chk("R11 lock cleared", PW'(lock_valid), 0);
    rd(2'd0, 2, d); chk("R11 code cleared", d, 0);
    wrc(2, 4'b0100);
    idle(4);
    rd(2'd0, 2, d); chk("R11 no stale move-in", d, 32'h4);
    rd(2'd1, 2, d); chk("R11 payload cleared", d, 0);
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule